// File: doc/BRIEF.md
# Two-Way Set-Associative Word Cache

This block is a small tag-and-data store for single-word blocks addressed by word. The address splits into a set index (its low bits, so the set is the address modulo the number of sets) and a tag (the remaining high bits). Each set holds two ways. Both ways of the selected set are compared with the tag in parallel. A valid way whose tag matches is a hit.

A read miss raises a fill request toward the next memory level and holds it until that level acknowledges with the data. The word is then installed and returned. A write always installs the write data into the cache and never fetches. Write data is not forwarded to memory; the user keeps memory coherent. On any miss, the lowest empty way of the set is filled. When both ways are valid, the way named by the set's recency bit is replaced. Every response reports whether the access hit, which way served it, and whether a valid block was displaced.

Top module: `cache2w`

## Requirements
- R1: After reset every way of every set is invalid, so the first access to any address misses. While idle after reset, req_ready_o is 1 and rsp_valid_o and mem_req_o are 0.
- R2: The set index is req_addr_i modulo NUM_SETS, which is its low log2(NUM_SETS) bits. The tag is the remaining high bits. Addresses that share an index but differ in tag compete for the same two ways.
- R3: A read whose tag matches a valid way of its set is a hit. rsp_valid_o is 1 in the cycle after acceptance, with rsp_hit_o=1, rsp_way_o set to the matching way, rsp_evict_o=0, and the stored word on rsp_rdata_o.
- R4: A read miss drives mem_req_o=1 with mem_addr_o equal to the request address from the cycle after acceptance until mem_ack_i is sampled high. While the fill is pending, req_ready_o is 0 and no response is given. The response follows in the cycle after the acknowledge, with rsp_hit_o=0 and mem_rdata_i on rsp_rdata_o.
- R5: On a miss in a set with an invalid way, the block goes into way 0 if way 0 is invalid, otherwise into way 1. rsp_evict_o is 0.
- R6: On a miss in a set whose two ways are both valid, the way marked least recently used is replaced and rsp_evict_o is 1.
- R7: Every hit, fill and write to a way marks the other way of that set as least recently used.
- R8: A write updates the word in the matching way on a hit. On a miss, it installs the write data into the victim way without raising mem_req_o. Its response returns the write data. A later read of that address hits and returns the written word.
- R9: With two sets and reads of words 0, 2, 0, 1, 4, 0, 2, 3, 5, 4 from reset, exactly 2 accesses hit (the third and the sixth). The fifth access evicts way 1 of set 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request; accepted when req_ready_o is 1 |
| req_addr_i | input | ADDR_W | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Block can accept an access |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_hit_o | output | 1 | Access hit |
| rsp_way_o | output | 1 | Way that served or received the block |
| rsp_evict_o | output | 1 | A valid block was displaced |
| rsp_rdata_o | output | DATA_W | Read data, or the write data for a write |
| mem_req_o | output | 1 | Fill request, held until acknowledged |
| mem_addr_o | output | ADDR_W | Fill address |
| mem_ack_i | input | 1 | Fill data valid |
| mem_rdata_i | input | DATA_W | Fill data |

## Verification
A wrong recency bit or valid bit does not show at the moment it goes wrong. It first appears at the next miss in the same set, as a wrong rsp_way_o or a wrong rsp_evict_o. It can also appear one access later as an unexpected miss, or as a hit that returns another address's word. The bench keeps an independent model of every set's contents and recency and compares each response with it. It uses reuse patterns that force replacement right after hits have reordered a set, so recency errors surface within two accesses. Fill timing is checked clock by clock, with acknowledge delays that vary from zero to several cycles.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_FILL = 1'b1} cache_state_e;

  // lowest empty way first, recency bit only when the set is full
  function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru;
  endfunction
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int NUM_SETS = 2,
  parameter int SET_W    = 1,
  parameter int TAG_W    = 7,
  parameter int DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  rd_set_i,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_SETS-1:0] vld_q;
  logic [TAG_W-1:0]    tag_q [NUM_SETS];
  logic [DATA_W-1:0]   dat_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_set_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_set_i] <= wr_tag_i;
      dat_q[wr_set_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = vld_q[rd_set_i];
  assign rd_tag_o   = tag_q[rd_set_i];
  assign rd_data_o  = dat_q[rd_set_i];
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int NUM_SETS = 2,
  parameter int SET_W    = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic             upd_en_i,
  input  logic [SET_W-1:0] upd_set_i,
  input  logic             used_way_i,
  output logic             lru_o
);
  logic [NUM_SETS-1:0] lru_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lru_q <= '0;
    else if (upd_en_i) lru_q[upd_set_i] <= ~used_way_i;
  end

  assign lru_o = lru_q[rd_set_i];
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int SET_W  = 1,
  parameter int TAG_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  input  logic              hit_i,
  input  logic              hit_way_i,
  input  logic [DATA_W-1:0] hit_data_i,
  input  logic              victim_i,
  input  logic              set_full_i,
  output logic [SET_W-1:0]  look_set_o,
  output logic [TAG_W-1:0]  look_tag_o,
  output logic              wr_en_o,
  output logic              way_sel_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              lru_upd_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_way_o,
  output logic              rsp_evict_o,
  output logic [DATA_W-1:0] rsp_rdata_o
);
  cache_state_e      state_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [ADDR_W-1:0] look_addr;
  logic              accept, fill_done, respond;

  assign accept    = req_valid_i && (state_q == ST_IDLE);
  assign fill_done = (state_q == ST_FILL) && mem_ack_i;
  assign respond   = (accept && (hit_i || req_we_i)) || fill_done;
  assign look_addr = (state_q == ST_FILL) ? pend_addr_q : req_addr_i;
  assign look_set_o = look_addr[SET_W-1:0];
  assign look_tag_o = look_addr[ADDR_W-1:SET_W];

  always_comb begin
    wr_en_o   = 1'b0;
    lru_upd_o = 1'b0;
    way_sel_o = victim_i;
    wr_data_o = req_wdata_i;
    if (accept) begin
      if (hit_i) begin
        way_sel_o = hit_way_i;
        lru_upd_o = 1'b1;
        wr_en_o   = req_we_i;
      end else if (req_we_i) begin
        wr_en_o   = 1'b1;
        lru_upd_o = 1'b1;
      end
    end
    if (fill_done) begin
      wr_en_o   = 1'b1;
      lru_upd_o = 1'b1;
      wr_data_o = mem_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pend_addr_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept && !hit_i && !req_we_i) begin
          state_q     <= ST_FILL;
          pend_addr_q <= req_addr_i;
        end
        ST_FILL: if (mem_ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= 1'b0;
      rsp_evict_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= respond;
      if (respond) begin
        rsp_hit_o   <= accept && hit_i;
        rsp_way_o   <= way_sel_o;
        rsp_evict_o <= !(accept && hit_i) && set_full_i;
        rsp_rdata_o <= fill_done ? mem_rdata_i : (req_we_i ? req_wdata_i : hit_data_i);
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_FILL);
  assign mem_addr_o  = pend_addr_q;
endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_SETS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_way_o,
  output logic              rsp_evict_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int WAYS  = 2;
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
  localparam int TAG_W = ADDR_W - SET_W;

  logic [SET_W-1:0]           look_set;
  logic [TAG_W-1:0]           look_tag;
  logic [WAYS-1:0]            way_vld, way_hit;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0][DATA_W-1:0] way_dat;
  logic                       hit, hit_way, victim, lru_bit, set_full;
  logic                       wr_en, way_sel, lru_upd;
  logic [DATA_W-1:0]          wr_data;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache2w_way #(
      .NUM_SETS(NUM_SETS), .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_set_i   (look_set),
      .wr_en_i    (wr_en && (way_sel == w[0])),
      .wr_set_i   (look_set),
      .wr_tag_i   (look_tag),
      .wr_data_i  (wr_data),
      .rd_valid_o (way_vld[w]),
      .rd_tag_o   (way_tag[w]),
      .rd_data_o  (way_dat[w])
    );
    assign way_hit[w] = way_vld[w] && (way_tag[w] == look_tag);
  end

  assign hit      = |way_hit;
  assign hit_way  = way_hit[1];
  assign set_full = &way_vld;
  assign victim   = pick_victim(way_vld, lru_bit);

  cache2w_lru #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_set_i   (look_set),
    .upd_en_i   (lru_upd),
    .upd_set_i  (look_set),
    .used_way_i (way_sel),
    .lru_o      (lru_bit)
  );

  cache2w_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_W), .TAG_W(TAG_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_we_i    (req_we_i),
    .req_wdata_i (req_wdata_i),
    .req_ready_o (req_ready_o),
    .hit_i       (hit),
    .hit_way_i   (hit_way),
    .hit_data_i  (way_dat[hit_way]),
    .victim_i    (victim),
    .set_full_i  (set_full),
    .look_set_o  (look_set),
    .look_tag_o  (look_tag),
    .wr_en_o     (wr_en),
    .way_sel_o   (way_sel),
    .wr_data_o   (wr_data),
    .lru_upd_o   (lru_upd),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_hit_o   (rsp_hit_o),
    .rsp_way_o   (rsp_way_o),
    .rsp_evict_o (rsp_evict_o),
    .rsp_rdata_o (rsp_rdata_o)
  );
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_we_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_evict_o,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o
);
  p_rsp_has_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(req_valid_i && req_ready_o) || $past(mem_req_o && mem_ack_i)));

  p_fill_blocks_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  p_fill_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_rsp_after_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> (rsp_valid_o && !rsp_hit_o && !mem_req_o));

  p_hit_no_evict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> !rsp_evict_o);

  p_write_no_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_we_i) |=> (!mem_req_o && rsp_valid_o));
endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_evict_o (rsp_evict_o),
  .mem_req_o   (mem_req_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/tb_cache2w.sv
`timescale 1ns/1ps
module tb_cache2w;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NSETS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_we = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid, rsp_hit, rsp_way, rsp_evict;
  logic [DW-1:0] rsp_rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  bit            mv [NSETS][2];
  int            mt [NSETS][2];
  logic [DW-1:0] md [NSETS][2];
  bit            ml [NSETS];

  always #4 clk = ~clk;

  cache2w #(.ADDR_W(AW), .DATA_W(DW), .NUM_SETS(NSETS)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_we_i(req_we),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_way_o(rsp_way),
    .rsp_evict_o(rsp_evict), .rsp_rdata_o(rsp_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [DW-1:0] fill_word(input int a);
    return 32'h5A00_0000 + a * 32'h0001_0203;
  endfunction

  task automatic chk(input string rq, input string what, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NSETS; s++) begin
      ml[s] = 1'b0;
      for (int w = 0; w < 2; w++) mv[s][w] = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    chk("R1", "req_ready after reset", {31'b0, req_ready}, 1);
    chk("R1", "rsp_valid after reset", {31'b0, rsp_valid}, 0);
    chk("R1", "mem_req after reset", {31'b0, mem_req}, 0);
  endtask

  task automatic access(input int a, input bit we, input logic [DW-1:0] wd, input int dly,
                        input string tag, output bit got_hit, output bit got_way,
                        output bit got_evict);
    int s = a % NSETS;
    int t = a / NSETS;
    bit h = 1'b0;
    bit w = 1'b0;
    bit ev;
    logic [DW-1:0] ed;
    string rq;
    for (int i = 0; i < 2; i++)
      if (mv[s][i] && mt[s][i] == t) begin h = 1'b1; w = i[0]; end
    if (!h) begin
      if (!mv[s][0])      w = 1'b0;
      else if (!mv[s][1]) w = 1'b1;
      else                w = ml[s];
    end
    ev = !h && mv[s][0] && mv[s][1];
    ed = we ? wd : (h ? md[s][w] : fill_word(a));
    rq = we ? "R8" : (h ? "R3" : (ev ? "R6" : "R5"));
    rq = {tag, "/", rq};

    @(negedge clk);
    chk(rq, "ready before request", {31'b0, req_ready}, 1);
    req_valid = 1'b1; req_addr = a[AW-1:0]; req_we = we; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    if (!h && !we) begin
      chk({tag, "/R4"}, "mem_req raised", {31'b0, mem_req}, 1);
      chk({tag, "/R4"}, "mem_addr", {24'b0, mem_addr}, a);
      for (int k = 0; k < dly; k++) begin
        chk({tag, "/R4"}, "no rsp while filling", {31'b0, rsp_valid}, 0);
        chk({tag, "/R4"}, "not ready while filling", {31'b0, req_ready}, 0);
        @(negedge clk);
        chk({tag, "/R4"}, "mem_req held", {31'b0, mem_req}, 1);
      end
      mem_ack = 1'b1; mem_rdata = fill_word(a);
      @(negedge clk);
      mem_ack = 1'b0; mem_rdata = '0;
    end else begin
      chk(rq, "no fetch", {31'b0, mem_req}, 0);
    end
    chk(rq, "rsp_valid", {31'b0, rsp_valid}, 1);
    chk(rq, "rsp_hit", {31'b0, rsp_hit}, {31'b0, h});
    chk(rq, "rsp_way", {31'b0, rsp_way}, {31'b0, w});
    chk(rq, "rsp_evict", {31'b0, rsp_evict}, {31'b0, ev});
    chk(rq, "rsp_rdata", rsp_rdata, ed);
    if (we || !h) begin
      mv[s][w] = 1'b1; mt[s][w] = t; md[s][w] = ed;
    end
    ml[s] = ~w;
    got_hit = h; got_way = rsp_way; got_evict = rsp_evict;
  endtask

  initial begin
    int seq [10] = '{0, 2, 0, 1, 4, 0, 2, 3, 5, 4};
    int hits;
    bit h, w, e;
    model_clear();
    do_reset();

    // R9 reference sequence, also R5/R6/R3 through the model
    hits = 0;
    for (int i = 0; i < 10; i++) begin
      access(seq[i], 1'b0, '0, i % 4, "R9", h, w, e);
      if (rsp_hit) hits++;
      if (i == 2 || i == 5) chk("R9", "expected hit", {31'b0, rsp_hit}, 1);
      if (i == 4) begin
        chk("R9", "fifth access evicts", {31'b0, rsp_evict}, 1);
        chk("R9", "fifth access way", {31'b0, rsp_way}, 1);
      end
    end
    chk("R9", "hit count", hits, 2);

    // R1: reset clears contents
    do_reset();
    access(0, 1'b0, '0, 1, "R1", h, w, e);
    chk("R1", "miss after reset", {31'b0, h}, 0);

    // R2: index is low bits, tag the rest
    do_reset();
    access(8, 1'b0, '0, 0, "R2", h, w, e);
    access(9, 1'b0, '0, 2, "R2", h, w, e);
    chk("R2", "other set way", {31'b0, w}, 0);
    access(8, 1'b0, '0, 0, "R2", h, w, e);
    chk("R2", "tag 4 set 0 hit", {31'b0, h}, 1);
    access(16, 1'b0, '0, 1, "R2", h, w, e);
    chk("R2", "same index new tag way", {31'b0, w}, 1);
    access(24, 1'b0, '0, 3, "R2", h, w, e);
    chk("R2", "third tag evicts", {31'b0, e}, 1);

    // R7: hits reorder recency before a replacement
    do_reset();
    access(0, 1'b0, '0, 0, "R7", h, w, e);
    access(2, 1'b0, '0, 0, "R7", h, w, e);
    access(2, 1'b0, '0, 0, "R7", h, w, e);
    access(0, 1'b0, '0, 0, "R7", h, w, e);
    access(6, 1'b0, '0, 1, "R7", h, w, e);
    chk("R7", "victim after hit on way0", {31'b0, w}, 1);
    access(2, 1'b0, '0, 1, "R7", h, w, e);
    chk("R7", "victim after fill of way1", {31'b0, w}, 0);

    // R8: write hit, write miss, read back
    access(6, 1'b1, 32'hDEAD_0006, 0, "R8", h, w, e);
    chk("R8", "write hit", {31'b0, h}, 1);
    access(6, 1'b0, '0, 0, "R8", h, w, e);
    chk("R8", "read written word", rsp_rdata, 32'hDEAD_0006);
    access(11, 1'b1, 32'hBEEF_000B, 0, "R8", h, w, e);
    chk("R8", "write miss", {31'b0, h}, 0);
    access(11, 1'b0, '0, 0, "R8", h, w, e);
    chk("R8", "read after write miss hits", {31'b0, h}, 1);
    chk("R8", "read after write miss data", rsp_rdata, 32'hBEEF_000B);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule